// File: doc/BRIEF.md
# Four-Way Symmetric Affine Source Coordinate Engine

This block produces source-image coordinates for an affine warp that uses backward mapping. Destination coordinates are taken relative to the image centre. Two nested counters walk one quarter of the centred destination plane. For each destination point, one pair of multiply-accumulates gives the transformed offset (x1, y1). Three more points follow from it through point symmetry about the centre. One of them is a negation. The other two are a precomputed shift of the first and its negation. Each step therefore emits four source coordinates at once.

The six transform coefficients come from one of two places. In general mode they are taken from input ports and cover scale, shear and translation. In rotation mode the block reads a cosine and a sine from an angle-indexed table. The coefficients are latched when a start pulse arrives, and the per-frame constants are formed in that same cycle. The block then issues one four-point step per cycle and signals completion with a done pulse. Downstream logic handles range checking, addressing and interpolation.

Top module: `aff_quad_engine`

## Requirements
- R1: While reset is asserted and after it is released, `pt_valid` is 0, `done` is 0 and every coordinate lane is 0 until a run starts.
- R2: Lane 0 carries the source point of destination (x, y). Its p value is round(a·x + b·y + tx + ROWS/2) and its q value is round(c·x + d·y + ty + COLS/2). Coefficients are signed Q4.12 (4096 = 1.0), tx and ty are signed integers, and round(v) = floor(v + 1/2). Lane i of `src_p` and `src_q` occupies bits [16·i+15 : 16·i] as a signed 16-bit value.
- R3: Lane 1 carries the source point of destination (x, y + COLS/2), evaluated with the same formula.
- R4: Lane 2 carries the source point of destination (−x, −y).
- R5: Lane 3 carries the source point of destination (−x, −y − COLS/2).
- R6: Steps follow this order. x runs from −floor((ROWS−1)/2) up to 0 in the outer loop. y runs from −floor((COLS−1)/2) up to 0 in the inner loop. Each loop advances by 1.
- R7: Call the clock edge that samples `start` high while idle E. `pt_valid` first goes high at the second edge after E. It then stays high for exactly one cycle per step, in consecutive cycles.
- R8: The four bits of `pt_valid` are always equal.
- R9: `done` is high for exactly one cycle. That cycle immediately follows the cycle of the last step, and `pt_valid` is 0 during it.
- R10: When `opn` = 1 at start, the coefficients become a = cos θ, b = −sin θ, c = sin θ, d = cos θ and tx = ty = 0. Here θ = `angle` × 22.5°, and each value is the nearest integer to 4096·cos θ or 4096·sin θ. The coefficient and shift ports are ignored.
- R11: A `start` pulse that arrives during a run has no effect. Changes on the parameter ports during a run have no effect either. The run's outputs stay those of the parameters latched at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latches parameters and begins a sweep when idle |
| opn | input | 1 | 1 selects rotation from the angle table, 0 selects port coefficients |
| angle | input | 4 | Rotation angle index, 22.5° per step |
| coef_a | input | 16 | Coefficient a, signed Q4.12 |
| coef_b | input | 16 | Coefficient b, signed Q4.12 |
| coef_c | input | 16 | Coefficient c, signed Q4.12 |
| coef_d | input | 16 | Coefficient d, signed Q4.12 |
| shift_x | input | 12 | Translation tx, signed integer |
| shift_y | input | 12 | Translation ty, signed integer |
| pt_valid | output | 4 | One strobe per coordinate lane |
| src_p | output | 64 | Four signed 16-bit p coordinates, lane i at bits 16·i+15..16·i |
| src_q | output | 64 | Four signed 16-bit q coordinates |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
Every lane of every step is compared against a direct evaluation of the affine equation at its mirrored destination point. A design that used the wrong sign on a constant, or applied the half-width shift to the wrong axis, would fail on lanes 1 and 3 only. Test vectors with negative coefficients and negative translation produce values at the exact rounding boundaries. Those cases expose arithmetic that truncates where it should round, or that shifts without sign extension. Rotation indices in all four quadrants catch a table that folds quadrants wrongly. A restart pulse in mid-sweep, together with junk on the parameter ports, catches a design that relatches or restarts its counters while a run is in progress.

// File: rtl/aff_pkg.sv
package aff_pkg;

    localparam int PW     = 16;   // coefficient width, Q4.12
    localparam int CW     = 12;   // coordinate / translation width
    localparam int FRAC   = 12;   // fractional bits
    localparam int OW     = 16;   // output coordinate width
    localparam int AW     = PW + CW + 4;
    localparam int ANG_W  = 4;
    localparam int LANES  = 4;

    typedef logic signed [PW-1:0] coef_t;
    typedef logic signed [CW-1:0] crd_t;
    typedef logic signed [AW-1:0] acc_t;
    typedef logic signed [OW-1:0] out_t;

    typedef struct packed {
        coef_t a;
        coef_t b;
        coef_t c;
        coef_t d;
        crd_t  tx;
        crd_t  ty;
    } xform_t;

    typedef struct packed {
        acc_t p;
        acc_t q;
    } pt_acc_t;

    typedef struct packed {
        coef_t cs;
        coef_t sn;
    } trig_t;

    typedef enum logic {ST_IDLE, ST_RUN} eng_state_t;

    // first-quadrant samples at 22.5 degree spacing
    function automatic trig_t trig_base(input logic [1:0] sub);
        trig_t t;
        case (sub)
            2'd0:    begin t.cs = 16'sd4096; t.sn = 16'sd0;    end
            2'd1:    begin t.cs = 16'sd3784; t.sn = 16'sd1567; end
            2'd2:    begin t.cs = 16'sd2896; t.sn = 16'sd2896; end
            default: begin t.cs = 16'sd1567; t.sn = 16'sd3784; end
        endcase
        return t;
    endfunction

    // nearest integer, halves toward +infinity
    function automatic out_t round_fix(input acc_t v);
        acc_t t;
        t = (v + acc_t'(1 <<< (FRAC - 1))) >>> FRAC;
        return t[OW-1:0];
    endfunction

endpackage

// File: rtl/aff_param_sel.sv
module aff_param_sel
    import aff_pkg::*;
(
    input  logic             opn,
    input  logic [ANG_W-1:0] angle,
    input  xform_t           ext,
    output xform_t           sel
);
    trig_t base;
    trig_t rot;

    always_comb begin
        base = trig_base(angle[1:0]);
        case (angle[ANG_W-1:ANG_W-2])
            2'd0:    begin rot.cs =  base.cs; rot.sn =  base.sn; end
            2'd1:    begin rot.cs = -base.sn; rot.sn =  base.cs; end
            2'd2:    begin rot.cs = -base.cs; rot.sn = -base.sn; end
            default: begin rot.cs =  base.sn; rot.sn = -base.cs; end
        endcase
        if (opn) begin
            sel.a  = rot.cs;
            sel.b  = -rot.sn;
            sel.c  = rot.sn;
            sel.d  = rot.cs;
            sel.tx = '0;
            sel.ty = '0;
        end else begin
            sel = ext;
        end
    end
endmodule

// File: rtl/aff_sweep.sv
module aff_sweep
    import aff_pkg::*;
#(
    parameter int X_FIRST = -3,
    parameter int Y_FIRST = -2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    output crd_t x,
    output crd_t y,
    output logic last
);
    localparam crd_t X0 = crd_t'(X_FIRST);
    localparam crd_t Y0 = crd_t'(Y_FIRST);

    assign last = (x == '0) && (y == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= X0;
            y <= Y0;
        end else if (load) begin
            x <= X0;
            y <= Y0;
        end else if (adv) begin
            if (y == '0) begin
                y <= Y0;
                x <= x + crd_t'(1);
            end else begin
                y <= y + crd_t'(1);
            end
        end
    end
endmodule

// File: rtl/aff_quad_out.sv
module aff_quad_out
    import aff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  crd_t             x,
    input  crd_t             y,
    input  coef_t            a,
    input  coef_t            b,
    input  coef_t            c,
    input  coef_t            d,
    input  pt_acc_t          e_k,
    input  pt_acc_t          dd_k,
    input  pt_acc_t          g_k,
    output logic [LANES*OW-1:0] p_out,
    output logic [LANES*OW-1:0] q_out
);
    acc_t x1;
    acc_t y1;

    always_comb begin
        x1 = acc_t'(a) * acc_t'(x) + acc_t'(b) * acc_t'(y);
        y1 = acc_t'(c) * acc_t'(x) + acc_t'(d) * acc_t'(y);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pt_acc_t base;
        acc_t    sp;
        acc_t    sq;
        if (i == 0) begin : g_b
            assign base = e_k;
        end else if (i == 1) begin : g_b
            assign base = dd_k;
        end else if (i == 2) begin : g_b
            assign base = e_k;
        end else begin : g_b
            assign base = g_k;
        end
        if (i < 2) begin : g_s
            assign sp = base.p + x1;
            assign sq = base.q + y1;
        end else begin : g_s
            assign sp = base.p - x1;
            assign sq = base.q - y1;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                p_out[i*OW +: OW] <= '0;
                q_out[i*OW +: OW] <= '0;
            end else if (en) begin
                p_out[i*OW +: OW] <= round_fix(sp);
                q_out[i*OW +: OW] <= round_fix(sq);
            end
        end
    end
endmodule

// File: rtl/aff_quad_engine.sv
module aff_quad_engine
    import aff_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  opn,
    input  logic [3:0]            angle,
    input  logic [15:0]           coef_a,
    input  logic [15:0]           coef_b,
    input  logic [15:0]           coef_c,
    input  logic [15:0]           coef_d,
    input  logic [11:0]           shift_x,
    input  logic [11:0]           shift_y,
    output logic [3:0]            pt_valid,
    output logic [63:0]           src_p,
    output logic [63:0]           src_q,
    output logic                  done
);
    localparam int OFF1    = ROWS / 2;
    localparam int OFF2    = COLS / 2;
    localparam int X_FIRST = -((ROWS - 1) / 2);
    localparam int Y_FIRST = -((COLS - 1) / 2);

    eng_state_t state;
    xform_t     ext;
    xform_t     sel;
    xform_t     prm_q;
    pt_acc_t    e_n, k_n, dd_n, g_n;
    pt_acc_t    e_q, dd_q, g_q;
    logic       accept;
    logic       running;
    logic       sw_last;
    logic       valid_q;
    logic       last_q;
    logic       done_q;
    crd_t       cur_x, cur_y;

    assign ext     = '{a: coef_t'(coef_a), b: coef_t'(coef_b),
                       c: coef_t'(coef_c), d: coef_t'(coef_d),
                       tx: crd_t'(shift_x), ty: crd_t'(shift_y)};
    assign running = (state == ST_RUN);
    assign accept  = (state == ST_IDLE) && start;

    aff_param_sel u_sel (
        .opn   (opn),
        .angle (angle),
        .ext   (ext),
        .sel   (sel)
    );

    // per-frame constants from the selected parameters
    always_comb begin
        e_n.p  = (acc_t'(sel.tx) + acc_t'(OFF1)) <<< FRAC;
        e_n.q  = (acc_t'(sel.ty) + acc_t'(OFF2)) <<< FRAC;
        k_n.p  = acc_t'(sel.b) * acc_t'(OFF2);
        k_n.q  = acc_t'(sel.d) * acc_t'(OFF2);
        dd_n.p = e_n.p + k_n.p;
        dd_n.q = e_n.q + k_n.q;
        g_n.p  = e_n.p - k_n.p;
        g_n.q  = e_n.q - k_n.q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            prm_q   <= '0;
            e_q     <= '0;
            dd_q    <= '0;
            g_q     <= '0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= running;
            last_q  <= running && sw_last;
            done_q  <= valid_q && last_q;
            case (state)
                ST_IDLE: if (start) begin
                    prm_q <= sel;
                    e_q   <= e_n;
                    dd_q  <= dd_n;
                    g_q   <= g_n;
                    state <= ST_RUN;
                end
                default: if (sw_last) state <= ST_IDLE;
            endcase
        end
    end

    aff_sweep #(.X_FIRST(X_FIRST), .Y_FIRST(Y_FIRST)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .adv  (running),
        .x    (cur_x),
        .y    (cur_y),
        .last (sw_last)
    );

    aff_quad_out u_out (
        .clk   (clk),
        .rst   (rst),
        .en    (running),
        .x     (cur_x),
        .y     (cur_y),
        .a     (prm_q.a),
        .b     (prm_q.b),
        .c     (prm_q.c),
        .d     (prm_q.d),
        .e_k   (e_q),
        .dd_k  (dd_q),
        .g_k   (g_q),
        .p_out (src_p),
        .q_out (src_q)
    );

    assign pt_valid = {LANES{valid_q}};
    assign done     = done_q;

    // translation fields are folded into the constants at start
    logic unused_ok;
    assign unused_ok = ^{prm_q.tx, prm_q.ty};
endmodule

// File: rtl/aff_engine_chk.sv
module aff_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [3:0] pt_valid,
    input logic       done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (pt_valid == 4'h0 && !done));

    // R8
    lanes_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (pt_valid == 4'h0 || pt_valid == 4'hF));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pt_valid == 4'h0 && $past(pt_valid) == 4'hF));

    // R7
    first_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pt_valid[0]) |-> $past(start, 2));
endmodule

bind aff_quad_engine aff_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pt_valid (pt_valid),
    .done     (done)
);

// File: tb/sim_aff_quad_engine.sv
module sim_aff_quad_engine;
    localparam int ROWS = 8;
    localparam int COLS = 6;
    localparam int OFF1 = ROWS / 2;
    localparam int OFF2 = COLS / 2;
    localparam int XS   = (ROWS - 1) / 2;
    localparam int YS   = (COLS - 1) / 2;
    localparam int NV   = 7;

    // vector table: opn, angle, a, b, c, d, tx, ty, disturb
    localparam int V_OPN[NV] = '{0, 0, 0, 0, 1, 1, 1};
    localparam int V_ANG[NV] = '{0, 0, 0, 0, 3, 10, 7};
    localparam int V_A[NV]   = '{4096, 6144, 4096, -3001, 111, -5, 77};
    localparam int V_B[NV]   = '{0, 0, 1229, 2777, -222, 6, 88};
    localparam int V_C[NV]   = '{0, 0, -819, 1913, 333, 7, 99};
    localparam int V_D[NV]   = '{4096, 2048, 4096, -4500, 444, -8, 11};
    localparam int V_TX[NV]  = '{0, 5, -2, 100, 9, -9, 40};
    localparam int V_TY[NV]  = '{0, -3, 7, -250, -9, 9, -40};
    localparam int V_DIS[NV] = '{0, 1, 0, 0, 1, 0, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        opn = 1'b0;
    logic [3:0]  angle = '0;
    logic [15:0] coef_a = '0, coef_b = '0, coef_c = '0, coef_d = '0;
    logic [11:0] shift_x = '0, shift_y = '0;
    logic [3:0]  pt_valid;
    logic [63:0] src_p, src_q;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    aff_quad_engine #(.ROWS(ROWS), .COLS(COLS)) u0 (
        .clk(clk), .rst(rst), .start(start), .opn(opn), .angle(angle),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_d(coef_d),
        .shift_x(shift_x), .shift_y(shift_y),
        .pt_valid(pt_valid), .src_p(src_p), .src_q(src_q), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint rnd(input longint v);
        return (v + 64'sd2048) >>> 12;
    endfunction

    function automatic longint q12(input real v);
        return longint'($floor(v * 4096.0 + 0.5));
    endfunction

    function automatic longint lane(input logic [63:0] bus, input int i);
        logic signed [15:0] s;
        s = bus[i*16 +: 16];
        return longint'(s);
    endfunction

    task automatic run_case(input int o, input int ang, input int a, input int b,
                            input int c, input int d, input int tx, input int ty,
                            input bit dis);
        longint ea, eb, ec, ed, etx, ety;
        int step;
        if (o != 0) begin
            real th;
            th  = real'(ang) * 22.5 * 3.14159265358979 / 180.0;
            ea  = q12($cos(th));
            ec  = q12($sin(th));
            eb  = -ec;
            ed  = ea;
            etx = 0;
            ety = 0;
        end else begin
            ea = a; eb = b; ec = c; ed = d; etx = tx; ety = ty;
        end
        opn     = (o != 0);
        angle   = 4'(ang);
        coef_a  = 16'(a);
        coef_b  = 16'(b);
        coef_c  = 16'(c);
        coef_d  = 16'(d);
        shift_x = 12'(tx);
        shift_y = 12'(ty);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(pt_valid == 4'h0, "R7", "valid one cycle after start", pt_valid, 0);
        if (dis) begin
            coef_a = 16'h7123; coef_b = 16'h8001; shift_x = 12'h7FF; opn = ~opn;
        end
        step = 0;
        for (int x = -XS; x <= 0; x++) begin
            for (int y = -YS; y <= 0; y++) begin
                longint ux[4], uy[4];
                @(negedge clk);
                if (dis && step == 3) begin
                    start = 1'b1; coef_d = 16'h1111; shift_y = 12'h801; angle = ~angle;
                end else if (dis && step == 4) begin
                    start = 1'b0;
                end
                check(pt_valid == 4'hF, "R7", "valid during step", pt_valid, 15);
                ux[0] = x;  uy[0] = y;
                ux[1] = x;  uy[1] = y + OFF2;
                ux[2] = -x; uy[2] = -y;
                ux[3] = -x; uy[3] = -y - OFF2;
                for (int i = 0; i < 4; i++) begin
                    longint ep, eq;
                    string rq;
                    ep = rnd(ea * ux[i] + eb * uy[i] + ((etx + OFF1) <<< 12));
                    eq = rnd(ec * ux[i] + ed * uy[i] + ((ety + OFF2) <<< 12));
                    rq = (i == 0) ? "R2" : (i == 1) ? "R3" : (i == 2) ? "R4" : "R5";
                    if (o != 0) rq = {rq, "/R10"};
                    if (dis) rq = {rq, "/R11"};
                    check(lane(src_p, i) == ep, rq, $sformatf("p lane%0d step%0d R6", i, step),
                          lane(src_p, i), ep);
                    check(lane(src_q, i) == eq, rq, $sformatf("q lane%0d step%0d R6", i, step),
                          lane(src_q, i), eq);
                end
                step++;
            end
        end
        @(negedge clk);
        check(done == 1'b1, "R9", "done after last step", done, 1);
        check(pt_valid == 4'h0, "R9", "valid low with done", pt_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done single cycle", done, 0);
        check(pt_valid == 4'h0, "R7", "no extra step", pt_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pt_valid == 4'h0 && done == 1'b0, "R1", "valid/done in reset",
              {pt_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(pt_valid == 4'h0 && done == 1'b0, "R1", "idle after reset",
              {pt_valid, done}, 0);
        check(src_p == 64'h0 && src_q == 64'h0, "R1", "lanes zero after reset",
              longint'(src_p[31:0] | src_q[31:0]), 0);
        for (int v = 0; v < NV; v++) begin
            run_case(V_OPN[v], V_ANG[v], V_A[v], V_B[v], V_C[v], V_D[v],
                     V_TX[v], V_TY[v], V_DIS[v] != 0);
        end
        // random general-mode parameters
        for (int r = 0; r < 3; r++) begin
            run_case(0, 0, int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                     int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                     int'($signed(10'($urandom))), int'($signed(10'($urandom))), 0);
        end
        // rotation in every quadrant, back to back
        for (int q = 0; q < 16; q += 5) begin
            run_case(1, q, 0, 0, 0, 0, 0, 0, 0);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule